// File: doc/BRIEF.md
# Macroblock Forward Transform Sequencer

This block takes the residual samples of one 4:2:0 macroblock, one 4x4 block per accepted beat, and turns them into transform coefficients. Every block passes through a fully parallel integer 4x4 DCT built from adders and shifts only. The DC term of every block is also kept aside. When all 24 blocks have arrived, the block replays the macroblock on its output stream. The DC terms are regrouped into a 4x4 Hadamard block for luma (intra 16x16 only) and a 2x2 Hadamard block for each chroma plane. Each DC block is sent ahead of the AC blocks it was taken from.

The producer marks each input beat with the plane it belongs to and with the prediction-mode flag. Luma blocks arrive in raster order of the 4x4 grid, then the four Cb blocks, then the four Cr blocks. The consumer receives 26 or 27 coefficient blocks. Each carries a tag that says what kind of block it is, so a later quantiser or scan stage can treat DC and AC blocks differently. The input stream stalls while a macroblock is drained. The output stream honours full back-pressure.

Top module: `mb_fwd_xform`

## Requirements
- R1: While reset is held, and right after it is released, out_valid is low and in_ready is high.
- R2: Sample p = 4*row + col of an input block sits at bits [IN_W*p +: IN_W] of in_resid. Coefficient p sits at bits [OUT_W*p +: OUT_W] of out_coef. The coefficients of a block equal C*X*C^T, with C rows (1,1,1,1), (2,1,-1,-2), (1,-1,-1,1) and (1,-2,2,-1).
- R3: With intra 16x16 selected, the first output block has tag 0. It equals (H*D*H^T + 1) >>> 1, where H has rows (1,1,1,1), (1,1,-1,-1), (1,-1,-1,1), (1,-1,1,-1) and D[r][c] is the DCT DC term of luma block 4r+c. The 16 luma blocks follow with tag 1 and coefficient 0 forced to zero.
- R4: With intra 16x16 not selected, no tag 0 block is produced. The 16 luma blocks are output with tag 2 and carry their full DCT, including coefficient 0.
- R5: in_kind is 0 for luma, 1 for Cb and 2 for Cr. After the luma blocks the output order is: one Cb DC block (tag 3), one Cr DC block (tag 4), the four Cb blocks (tag 5), then the four Cr blocks (tag 6). Within each plane, blocks keep their arrival order.
- R6: A chroma DC block holds d0+d1+d2+d3, d0-d1+d2-d3, d0+d1-d2-d3 and d0-d1-d2+d3 at positions 0 to 3, where dk is the DC term of the k-th block of that plane. Positions 4 to 15 are zero. No scaling is applied.
- R7: Cb and Cr AC blocks carry their DCT with coefficient 0 forced to zero.
- R8: out_valid rises in the cycle after the 24th block is accepted. in_ready stays low until the last output block is taken, and input beats offered meanwhile have no effect. in_ready is high again in the next cycle.
- R9: While out_valid is high and out_ready is low, out_valid, out_coef and out_tag hold their values.
- R10: The mode flag is sampled only with the first block of a macroblock. Its value on the other 23 blocks has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Input block accepted when high together with in_valid |
| in_resid | input | 16*IN_W | Sixteen signed residual samples |
| in_i16 | input | 1 | Intra 16x16 prediction flag, read from the first block only |
| in_kind | input | 2 | Plane of the block: 0 luma, 1 Cb, 2 Cr |
| out_valid | output | 1 | Coefficient block offered |
| out_ready | input | 1 | Consumer takes the block |
| out_coef | output | 16*OUT_W | Sixteen signed coefficients |
| out_tag | output | 3 | Block kind: 0 luma DC, 1 luma AC, 2 luma full, 3 Cb DC, 4 Cr DC, 5 Cb AC, 6 Cr AC |

## Verification
The ordering properties assume that every macroblock delivers exactly sixteen luma, four Cb and four Cr blocks with in_kind limited to 0..2. The stimulus always sends complete macroblocks in plane order, with idle gaps, and never uses kind 3. The hold property on the output assumes nothing about the consumer, so the bench mixes always-ready, mostly-ready and mostly-stalled consumers. It also offers junk input beats during every drain and inverts the mode flag on every block after the first, so that the drain stall and the mode sampling can be seen at the ports.

// File: rtl/fxf_pkg.sv
package fxf_pkg;

  localparam int LUMA_BLKS   = 16;
  localparam int CHROMA_BLKS = 4;
  localparam int MB_BLKS     = LUMA_BLKS + 2 * CHROMA_BLKS;
  localparam int BLK_SAMPLES = 16;

  typedef enum logic [1:0] {
    KIND_Y  = 2'd0,
    KIND_CB = 2'd1,
    KIND_CR = 2'd2
  } blk_kind_e;

  // output tag codes; the ordering logic and consumers decode them
  typedef enum logic [2:0] {
    TAG_Y_DC   = 3'd0,
    TAG_Y_AC   = 3'd1,
    TAG_Y_FULL = 3'd2,
    TAG_CB_DC  = 3'd3,
    TAG_CR_DC  = 3'd4,
    TAG_CB_AC  = 3'd5,
    TAG_CR_AC  = 3'd6
  } coef_tag_e;

  typedef enum logic {
    ST_FILL  = 1'b0,
    ST_DRAIN = 1'b1
  } seq_state_e;

endpackage

// File: rtl/fxf_dct4x4.sv
// Fully parallel 4x4 integer DCT: butterflies on rows, then on columns.
module fxf_dct4x4 #(
  parameter int IN_W  = 9,
  parameter int OUT_W = 16
) (
  input  logic [16*IN_W-1:0]  blk_i,
  output logic [16*OUT_W-1:0] coef_o
);

  localparam int MID_W = IN_W + 3;   // row gain is at most 6

  logic signed [IN_W-1:0]  x [4][4];
  logic signed [MID_W-1:0] r [4][4];
  logic signed [OUT_W-1:0] c [4][4];

  always_comb begin
    logic signed [MID_W-1:0] rs0, rs1, rd0, rd1;
    logic signed [OUT_W-1:0] cs0, cs1, cd0, cd1;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        x[i][j] = blk_i[(i*4+j)*IN_W +: IN_W];
      end
    end
    // row pass: r = X * C^T
    for (int i = 0; i < 4; i++) begin
      rs0 = MID_W'(x[i][0]) + MID_W'(x[i][3]);
      rs1 = MID_W'(x[i][1]) + MID_W'(x[i][2]);
      rd0 = MID_W'(x[i][0]) - MID_W'(x[i][3]);
      rd1 = MID_W'(x[i][1]) - MID_W'(x[i][2]);
      r[i][0] = rs0 + rs1;
      r[i][1] = (rd0 <<< 1) + rd1;
      r[i][2] = rs0 - rs1;
      r[i][3] = rd0 - (rd1 <<< 1);
    end
    // column pass: c = C * r
    for (int j = 0; j < 4; j++) begin
      cs0 = OUT_W'(r[0][j]) + OUT_W'(r[3][j]);
      cs1 = OUT_W'(r[1][j]) + OUT_W'(r[2][j]);
      cd0 = OUT_W'(r[0][j]) - OUT_W'(r[3][j]);
      cd1 = OUT_W'(r[1][j]) - OUT_W'(r[2][j]);
      c[0][j] = cs0 + cs1;
      c[1][j] = (cd0 <<< 1) + cd1;
      c[2][j] = cs0 - cs1;
      c[3][j] = cd0 - (cd1 <<< 1);
    end
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        coef_o[(k*4+j)*OUT_W +: OUT_W] = c[k][j];
      end
    end
  end

endmodule

// File: rtl/fxf_had4x4.sv
// 4x4 Hadamard over the luma DC matrix, halved with rounding.
module fxf_had4x4 #(
  parameter int OUT_W = 16
) (
  input  logic [16*OUT_W-1:0] dc_i,
  output logic [16*OUT_W-1:0] had_o
);

  localparam int ACC_W = OUT_W + 4;

  logic signed [OUT_W-1:0] x [4][4];
  logic signed [ACC_W-1:0] r [4][4];
  logic signed [ACC_W-1:0] y [4][4];

  always_comb begin
    logic signed [ACC_W-1:0] s0, s1, d0, d1, rnd;
    for (int i = 0; i < 4; i++) begin
      for (int j = 0; j < 4; j++) begin
        x[i][j] = dc_i[(i*4+j)*OUT_W +: OUT_W];
      end
    end
    for (int i = 0; i < 4; i++) begin
      s0 = ACC_W'(x[i][0]) + ACC_W'(x[i][3]);
      s1 = ACC_W'(x[i][1]) + ACC_W'(x[i][2]);
      d0 = ACC_W'(x[i][0]) - ACC_W'(x[i][3]);
      d1 = ACC_W'(x[i][1]) - ACC_W'(x[i][2]);
      r[i][0] = s0 + s1;
      r[i][1] = d0 + d1;
      r[i][2] = s0 - s1;
      r[i][3] = d0 - d1;
    end
    for (int j = 0; j < 4; j++) begin
      s0 = r[0][j] + r[3][j];
      s1 = r[1][j] + r[2][j];
      d0 = r[0][j] - r[3][j];
      d1 = r[1][j] - r[2][j];
      y[0][j] = s0 + s1;
      y[1][j] = d0 + d1;
      y[2][j] = s0 - s1;
      y[3][j] = d0 - d1;
    end
    for (int k = 0; k < 4; k++) begin
      for (int j = 0; j < 4; j++) begin
        rnd = (y[k][j] + ACC_W'(1)) >>> 1;
        had_o[(k*4+j)*OUT_W +: OUT_W] = OUT_W'(rnd);
      end
    end
  end

endmodule

// File: rtl/fxf_had2x2.sv
// 2x2 Hadamard over one chroma plane's DC terms, unscaled.
module fxf_had2x2 #(
  parameter int OUT_W = 16
) (
  input  logic [4*OUT_W-1:0]  dc_i,
  output logic [16*OUT_W-1:0] had_o
);

  localparam int ACC_W = OUT_W + 2;

  logic signed [ACC_W-1:0] d [4];
  logic signed [ACC_W-1:0] y [4];

  always_comb begin
    for (int k = 0; k < 4; k++) begin
      d[k] = ACC_W'($signed(dc_i[k*OUT_W +: OUT_W]));
    end
    y[0] = d[0] + d[1] + d[2] + d[3];
    y[1] = d[0] - d[1] + d[2] - d[3];
    y[2] = d[0] + d[1] - d[2] - d[3];
    y[3] = d[0] - d[1] - d[2] + d[3];
    had_o = '0;
    for (int k = 0; k < 4; k++) begin
      had_o[k*OUT_W +: OUT_W] = OUT_W'(y[k]);
    end
  end

endmodule

// File: rtl/mb_fwd_xform.sv
module mb_fwd_xform
  import fxf_pkg::*;
#(
  parameter int IN_W  = 9,
  parameter int OUT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [16*IN_W-1:0]   in_resid,
  input  logic                 in_i16,
  input  logic [1:0]           in_kind,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [16*OUT_W-1:0]  out_coef,
  output logic [2:0]           out_tag
);

  localparam int BLK_W  = BLK_SAMPLES * OUT_W;
  localparam int SLOT_W = $clog2(MB_BLKS);
  localparam int LCNT_W = $clog2(LUMA_BLKS + 1);
  localparam int CCNT_W = $clog2(CHROMA_BLKS + 1);
  localparam int N_OUT  = 1 + LUMA_BLKS + 2 + 2 * CHROMA_BLKS;
  localparam int IDX_W  = $clog2(N_OUT);

  localparam logic [LCNT_W-1:0] LCNT_FULL = LCNT_W'(LUMA_BLKS);
  localparam logic [CCNT_W-1:0] CCNT_FULL = CCNT_W'(CHROMA_BLKS);
  localparam logic [IDX_W-1:0]  D_Y_DC    = IDX_W'(0);
  localparam logic [IDX_W-1:0]  D_Y_FIRST = IDX_W'(1);
  localparam logic [IDX_W-1:0]  D_Y_LAST  = IDX_W'(LUMA_BLKS);
  localparam logic [IDX_W-1:0]  D_CB_DC   = IDX_W'(LUMA_BLKS + 1);
  localparam logic [IDX_W-1:0]  D_CR_DC   = IDX_W'(LUMA_BLKS + 2);
  localparam logic [IDX_W-1:0]  D_CB_LAST = IDX_W'(LUMA_BLKS + 2 + CHROMA_BLKS);
  localparam logic [IDX_W-1:0]  D_LAST    = IDX_W'(N_OUT - 1);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  // sequencer state
  seq_state_e        st_q, st_n;
  logic [LCNT_W-1:0] lcnt_q, lcnt_n;
  logic [CCNT_W-1:0] cbcnt_q, cbcnt_n, crcnt_q, crcnt_n;
  logic              mode_q, mode_n;
  logic [IDX_W-1:0]  didx_q, didx_n;

  logic              accept, slot_ok, buf_we, mb_first;
  logic [SLOT_W-1:0] wslot;
  blk_kind_e         kind;

  // transform datapath and the two buffers
  logic [BLK_W-1:0] dct_blk;
  logic [BLK_W-1:0] ac_buf [MB_BLKS];
  logic [OUT_W-1:0] dc_buf [MB_BLKS];
  logic [BLK_W-1:0] had_y;
  logic [BLK_W-1:0] had_c [2];
  logic [BLK_W-1:0] dc_y_pack;
  logic [4*OUT_W-1:0] dc_c_pack [2];

  fxf_dct4x4 #(.IN_W(IN_W), .OUT_W(OUT_W)) u_dct (
    .blk_i  (in_resid),
    .coef_o (dct_blk)
  );

  for (genvar k = 0; k < LUMA_BLKS; k++) begin : g_ydc
    assign dc_y_pack[k*OUT_W +: OUT_W] = dc_buf[k];
  end

  fxf_had4x4 #(.OUT_W(OUT_W)) u_had_y (
    .dc_i  (dc_y_pack),
    .had_o (had_y)
  );

  for (genvar g = 0; g < 2; g++) begin : g_chroma
    for (genvar k = 0; k < CHROMA_BLKS; k++) begin : g_cdc
      assign dc_c_pack[g][k*OUT_W +: OUT_W] = dc_buf[LUMA_BLKS + g*CHROMA_BLKS + k];
    end
    fxf_had2x2 #(.OUT_W(OUT_W)) u_had_c (
      .dc_i  (dc_c_pack[g]),
      .had_o (had_c[g])
    );
  end

  // write side
  assign kind     = blk_kind_e'(in_kind);
  assign in_ready = (st_q == ST_FILL);
  assign accept   = in_ready && in_valid;
  assign mb_first = (lcnt_q == '0) && (cbcnt_q == '0) && (crcnt_q == '0);
  assign buf_we   = accept && slot_ok;

  always_comb begin
    slot_ok = 1'b0;
    wslot   = '0;
    unique case (kind)
      KIND_Y: begin
        slot_ok = (lcnt_q != LCNT_FULL);
        wslot   = SLOT_W'(lcnt_q);
      end
      KIND_CB: begin
        slot_ok = (cbcnt_q != CCNT_FULL);
        wslot   = SLOT_W'(LUMA_BLKS) + SLOT_W'(cbcnt_q);
      end
      KIND_CR: begin
        slot_ok = (crcnt_q != CCNT_FULL);
        wslot   = SLOT_W'(LUMA_BLKS + CHROMA_BLKS) + SLOT_W'(crcnt_q);
      end
      default: ;
    endcase
  end

  // next state
  always_comb begin
    st_n    = st_q;
    lcnt_n  = lcnt_q;
    cbcnt_n = cbcnt_q;
    crcnt_n = crcnt_q;
    mode_n  = mode_q;
    didx_n  = didx_q;
    if (st_q == ST_FILL) begin
      if (accept) begin
        if (mb_first) mode_n = in_i16;
        if (slot_ok) begin
          if (kind == KIND_Y)  lcnt_n  = lcnt_q + LCNT_W'(1);
          if (kind == KIND_CB) cbcnt_n = cbcnt_q + CCNT_W'(1);
          if (kind == KIND_CR) crcnt_n = crcnt_q + CCNT_W'(1);
        end
        if (lcnt_n == LCNT_FULL && cbcnt_n == CCNT_FULL && crcnt_n == CCNT_FULL) begin
          st_n   = ST_DRAIN;
          didx_n = mode_n ? D_Y_DC : D_Y_FIRST;
        end
      end
    end else if (out_ready) begin
      if (didx_q == D_LAST) begin
        st_n    = ST_FILL;
        lcnt_n  = '0;
        cbcnt_n = '0;
        crcnt_n = '0;
      end else begin
        didx_n = didx_q + IDX_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      st_q    <= ST_FILL;
      lcnt_q  <= '0;
      cbcnt_q <= '0;
      crcnt_q <= '0;
      mode_q  <= 1'b0;
      didx_q  <= '0;
    end else begin
      st_q    <= st_n;
      lcnt_q  <= lcnt_n;
      cbcnt_q <= cbcnt_n;
      crcnt_q <= crcnt_n;
      mode_q  <= mode_n;
      didx_q  <= didx_n;
    end
  end

  // data buffers: clock-enabled, no reset needed
  always_ff @(posedge clk) begin
    if (buf_we) begin
      ac_buf[wslot] <= dct_blk;
      dc_buf[wslot] <= dct_blk[OUT_W-1:0];
    end
  end

  // read side
  logic [IDX_W-1:0] rd_idx;
  coef_tag_e        tag_c;

  assign rd_idx    = (didx_q <= D_Y_LAST) ? (didx_q - IDX_W'(1)) : (didx_q - IDX_W'(3));
  assign out_valid = (st_q == ST_DRAIN);
  assign out_tag   = tag_c;

  always_comb begin
    out_coef = ac_buf[rd_idx[SLOT_W-1:0]];
    tag_c    = TAG_Y_FULL;
    if (didx_q == D_Y_DC) begin
      out_coef = had_y;
      tag_c    = TAG_Y_DC;
    end else if (didx_q <= D_Y_LAST) begin
      if (mode_q) begin
        tag_c                = TAG_Y_AC;
        out_coef[OUT_W-1:0]  = '0;
      end
    end else if (didx_q == D_CB_DC) begin
      out_coef = had_c[0];
      tag_c    = TAG_CB_DC;
    end else if (didx_q == D_CR_DC) begin
      out_coef = had_c[1];
      tag_c    = TAG_CR_DC;
    end else begin
      tag_c               = (didx_q <= D_CB_LAST) ? TAG_CB_AC : TAG_CR_AC;
      out_coef[OUT_W-1:0] = '0;
    end
  end

endmodule

// File: rtl/fxf_chk.sv
module fxf_chk
  import fxf_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [16*OUT_W-1:0] out_coef,
  input logic [2:0]          out_tag
);

  p_hold_on_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_coef) && $stable(out_tag));

  p_input_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);

  p_luma_ac_no_dc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_tag == TAG_Y_AC |-> out_coef[OUT_W-1:0] == '0);

  p_ydc_then_yac_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_tag == TAG_Y_DC |=> out_valid && out_tag == TAG_Y_AC);

  p_chroma_ac_no_dc_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_tag == TAG_CB_AC || out_tag == TAG_CR_AC) |-> out_coef[OUT_W-1:0] == '0);

  p_chroma_dc_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (out_tag == TAG_CB_DC || out_tag == TAG_CR_DC) |-> out_coef[16*OUT_W-1:4*OUT_W] == '0);

  p_cr_dc_after_cb_dc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_tag == TAG_CB_DC |=> out_valid && out_tag == TAG_CR_DC);

  p_tag_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_tag <= TAG_CR_AC);

endmodule

bind mb_fwd_xform fxf_chk #(.OUT_W(OUT_W)) u_fxf_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_coef  (out_coef),
  .out_tag   (out_tag)
);

// File: tb/tb_mb_fwd_xform.sv
module tb_mb_fwd_xform;

  localparam int CLK_PERIOD = 10;
  localparam int IN_W       = 9;
  localparam int OUT_W      = 16;
  localparam int WD_CYCLES  = 50000;

  logic                clk;
  logic                rst_n;
  logic                in_valid;
  logic                in_ready;
  logic [16*IN_W-1:0]  in_resid;
  logic                in_i16;
  logic [1:0]          in_kind;
  logic                out_valid;
  logic                out_ready;
  logic [16*OUT_W-1:0] out_coef;
  logic [2:0]          out_tag;

  mb_fwd_xform #(.IN_W(IN_W), .OUT_W(OUT_W)) dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_resid(in_resid),
    .in_i16(in_i16), .in_kind(in_kind),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_coef(out_coef), .out_tag(out_tag)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int errors = 0;
  int checks = 0;
  int res  [24][16];
  int ydct [24][16];
  int exp_c[27][16];
  int exp_t[27];
  int n_exp;
  int seed = 32'h1234_5678;

  function automatic int cdct(int u, int j);
    case (u)
      0: return 1;
      1: return (j == 0) ? 2 : (j == 1) ? 1 : (j == 2) ? -1 : -2;
      2: return (j == 0 || j == 3) ? 1 : -1;
      default: return (j == 0) ? 1 : (j == 1) ? -2 : (j == 2) ? 2 : -1;
    endcase
  endfunction

  function automatic int chad(int u, int j);
    case (u)
      0: return 1;
      1: return (j < 2) ? 1 : -1;
      2: return (j == 0 || j == 3) ? 1 : -1;
      default: return (j % 2 == 0) ? 1 : -1;
    endcase
  endfunction

  function automatic string req_of(int t, int p);
    if (t == 0) return "R3";
    if (t == 1) return (p == 0) ? "R3" : "R2";
    if (t == 2) return "R4";
    if (t <= 4) return "R6";
    return (p == 0) ? "R7" : "R2";
  endfunction

  task automatic fill_pat(int pat);
    for (int b = 0; b < 24; b++) begin
      for (int p = 0; p < 16; p++) begin
        case (pat)
          0: begin
            seed = seed * 1103515245 + 12345;
            res[b][p] = ((seed >>> 16) & 511) - 256;
          end
          1: res[b][p] = 255;
          2: res[b][p] = -256;
          default: res[b][p] = (((p / 4) + (p % 4) + b) % 2 == 0) ? 255 : -256;
        endcase
      end
    end
  endtask

  // expected stream, from the requirement formulas
  task automatic build_expected(bit i16);
    int acc;
    int d [4];
    for (int b = 0; b < 24; b++) begin
      for (int u = 0; u < 4; u++) begin
        for (int v = 0; v < 4; v++) begin
          acc = 0;
          for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
              acc += cdct(u, i) * res[b][i*4+j] * cdct(v, j);
          ydct[b][u*4+v] = acc;
        end
      end
    end
    n_exp = 0;
    if (i16) begin
      for (int u = 0; u < 4; u++) begin
        for (int v = 0; v < 4; v++) begin
          acc = 0;
          for (int i = 0; i < 4; i++)
            for (int j = 0; j < 4; j++)
              acc += chad(u, i) * ydct[i*4+j][0] * chad(v, j);
          exp_c[0][u*4+v] = (acc + 1) >>> 1;
        end
      end
      exp_t[0] = 0;
      n_exp = 1;
    end
    for (int b = 0; b < 16; b++) begin
      for (int p = 0; p < 16; p++) exp_c[n_exp][p] = ydct[b][p];
      if (i16) exp_c[n_exp][0] = 0;
      exp_t[n_exp] = i16 ? 1 : 2;
      n_exp++;
    end
    for (int g = 0; g < 2; g++) begin
      for (int k = 0; k < 4; k++) d[k] = ydct[16 + 4*g + k][0];
      for (int p = 0; p < 16; p++) exp_c[n_exp][p] = 0;
      exp_c[n_exp][0] = d[0] + d[1] + d[2] + d[3];
      exp_c[n_exp][1] = d[0] - d[1] + d[2] - d[3];
      exp_c[n_exp][2] = d[0] + d[1] - d[2] - d[3];
      exp_c[n_exp][3] = d[0] - d[1] - d[2] + d[3];
      exp_t[n_exp] = 3 + g;
      n_exp++;
    end
    for (int b = 16; b < 24; b++) begin
      for (int p = 0; p < 16; p++) exp_c[n_exp][p] = ydct[b][p];
      exp_c[n_exp][0] = 0;
      exp_t[n_exp] = (b < 20) ? 5 : 6;
      n_exp++;
    end
  endtask

  // R10: flag is the real mode only on block 0, inverted on all others
  task automatic send_mb(bit i16, bit gaps);
    for (int b = 0; b < 24; b++) begin
      if (gaps && (b % 5 == 2)) begin
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
      end
      @(negedge clk);
      checks++;
      if (in_ready !== 1'b1) begin
        errors++;
        $display("FAIL R8 in_ready during fill: got %b expected 1", in_ready);
      end
      in_valid = 1'b1;
      in_i16   = (b == 0) ? i16 : !i16;
      in_kind  = (b < 16) ? 2'd0 : (b < 20) ? 2'd1 : 2'd2;
      for (int p = 0; p < 16; p++) in_resid[p*IN_W +: IN_W] = IN_W'(res[b][p]);
      @(posedge clk);
    end
  endtask

  task automatic recv_mb(int stall);
    int idx = 0;
    int cyc = 0;
    int bad;
    int got;
    bit hold = 1'b0;
    logic [16*OUT_W-1:0] sv_coef;
    logic [2:0]          sv_tag;
    while (idx < n_exp) begin
      @(negedge clk);
      // junk offered while draining must be ignored (R8)
      in_valid = 1'b1;
      in_kind  = 2'(cyc % 3);
      in_i16   = cyc[0];
      for (int p = 0; p < 16; p++) in_resid[p*IN_W +: IN_W] = IN_W'(cyc * 7 + p);
      case (stall)
        0: out_ready = 1'b1;
        1: out_ready = (cyc % 3) != 1;
        default: out_ready = (cyc % 4) == 3;
      endcase
      checks++;
      if (out_valid !== 1'b1 || in_ready !== 1'b0) begin
        errors++;
        $display("FAIL R8 drain handshake: got valid=%b ready=%b expected valid=1 ready=0",
                 out_valid, in_ready);
      end
      if (hold) begin
        checks++;
        if (out_coef !== sv_coef || out_tag !== sv_tag) begin
          errors++;
          $display("FAIL R9 stalled output changed: got tag %0d expected tag %0d", out_tag, sv_tag);
        end
        hold = 1'b0;
      end
      if (out_valid && out_ready) begin
        checks++;
        if (int'(out_tag) != exp_t[idx]) begin
          errors++;
          $display("FAIL R5 block %0d tag: got %0d expected %0d", idx, out_tag, exp_t[idx]);
        end
        bad = -1;
        for (int p = 0; p < 16; p++) begin
          got = int'($signed(out_coef[p*OUT_W +: OUT_W]));
          if (got != exp_c[idx][p] && bad < 0) bad = p;
        end
        checks++;
        if (bad >= 0) begin
          errors++;
          $display("FAIL %s block %0d pos %0d: got %0d expected %0d", req_of(exp_t[idx], bad),
                   idx, bad, int'($signed(out_coef[bad*OUT_W +: OUT_W])), exp_c[idx][bad]);
        end
        idx++;
      end else if (out_valid) begin
        hold    = 1'b1;
        sv_coef = out_coef;
        sv_tag  = out_tag;
      end
      cyc++;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid  = 1'b0;
    out_ready = 1'b0;
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R8 after drain: got valid=%b ready=%b expected valid=0 ready=1",
               out_valid, in_ready);
    end
  endtask

  task automatic run_mb(int pat, bit i16, bit gaps, int stall);
    fill_pat(pat);
    build_expected(i16);
    send_mb(i16, gaps);
    recv_mb(stall);
  endtask

  initial begin
    rst_n     = 1'b0;
    in_valid  = 1'b0;
    in_resid  = '0;
    in_i16    = 1'b0;
    in_kind   = 2'd0;
    out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 in reset: got valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      errors++;
      $display("FAIL R1 after release: got valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end

    run_mb(0, 1'b1, 1'b0, 0);   // R3 random intra 16x16
    run_mb(0, 1'b0, 1'b1, 1);   // R4 random other mode, stalls (R9)
    run_mb(1, 1'b1, 1'b0, 2);   // R3 positive extreme
    run_mb(2, 1'b1, 1'b1, 1);   // R3 negative extreme
    run_mb(3, 1'b0, 1'b0, 2);   // R4 R6 checkerboard
    run_mb(2, 1'b0, 1'b0, 0);   // R4 negative extreme
    run_mb(0, 1'b1, 1'b1, 1);   // R10 R7 random again

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: got no completion expected finish within %0d cycles", WD_CYCLES);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule